// File: doc/BRIEF.md
# Post-Update Floating-Point Load Unit

This block carries out four floating-point loads that move their base register forward once the access is made. An issued operation selects single or double precision and picks displacement or indexed addressing. The operation brings the base register value, a signed 16-bit displacement or an index register value, the base register number and the target floating-point register number. The unit reads memory at the base value as it was before the operation. It also forms the new address, which is the base plus the offset. One memory read goes out over a valid/ready request port, and the unit then waits for a single response beat that carries 64 bits.

When the response arrives, the unit writes back two registers in the same cycle. The target floating-point register receives the loaded value. A single-precision word is first widened to the 64-bit double format, and a doubleword passes through unchanged. The base general-purpose register receives the new address. If the base register number is zero, the form is invalid: the unit raises a one-cycle flag and makes no memory request and no writeback. No status registers are involved.

Top module: `fpld_postinc_unit`

## Requirements
- R1: In displacement form (`op_indexed`=0), `gpr_wb_data` equals `base_val` plus `disp` sign-extended to 64 bits.
- R2: In indexed form (`op_indexed`=1), `gpr_wb_data` equals `base_val` plus `index_val`.
- R3: `mem_req_addr` equals the unmodified `base_val`, and `mem_req_valid` is high in the cycle after the operation is accepted.
- R4: `mem_req_size` is the byte count: 4 for single precision (`op_double`=0) and 8 for double precision (`op_double`=1).
- R5: For single precision, the word is `mem_rsp_data[31:0]` and bits 63:32 are ignored. The sign is kept, and a normal exponent is rebiased by +896. The 23-bit fraction becomes the top of the 52-bit fraction. Exponent 0 with fraction 0 maps to a signed zero, and exponent 255 maps to exponent 2047 with the fraction (including any NaN payload) left-aligned.
- R6: A subnormal single (exponent 0, fraction nonzero) whose leading one is at fraction bit p becomes a normal double with exponent 874+p. The bits below that leading one become the top of the 52-bit fraction.
- R7: For double precision, `fpr_wb_data` equals `mem_rsp_data` unchanged.
- R8: The cycle after `mem_rsp_valid`, `fpr_wb_valid` and `gpr_wb_valid` are high together for exactly one cycle, with `fpr_wb_idx`=`tgt_idx` and `gpr_wb_idx`=`base_idx`.
- R9: If `base_idx` is 0, `invalid_flag` is high for exactly one cycle after acceptance, and there is no memory request and no writeback.
- R10: While `mem_req_ready` is low, `mem_req_valid` stays high with `mem_req_addr` and `mem_req_size` stable. The request drops the cycle after the handshake.
- R11: After reset, `issue_ready` is 1 and `mem_req_valid`, both writeback valids and `invalid_flag` are 0. A reset in mid-operation abandons the request.
- R12: Address arithmetic is 64-bit and wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Operation presented |
| issue_ready | output | 1 | Unit idle and able to accept |
| op_double | input | 1 | 1 = double precision, 0 = single |
| op_indexed | input | 1 | 1 = indexed form, 0 = displacement form |
| base_val | input | 64 | Base register value |
| disp | input | 16 | Signed displacement |
| index_val | input | 64 | Index register value |
| base_idx | input | 5 | Base register number |
| tgt_idx | input | 5 | Target floating-point register number |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted by memory |
| mem_req_addr | output | 64 | Read byte address |
| mem_req_size | output | 4 | Read size in bytes (4 or 8) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-justified for 4-byte reads |
| fpr_wb_valid | output | 1 | Floating-point writeback valid |
| fpr_wb_idx | output | 5 | Floating-point writeback register |
| fpr_wb_data | output | 64 | Floating-point writeback value |
| gpr_wb_valid | output | 1 | Base register writeback valid |
| gpr_wb_idx | output | 5 | Base register writeback number |
| gpr_wb_data | output | 64 | New base address |
| invalid_flag | output | 1 | One-cycle pulse for an invalid form |

## Verification
The bench sends a negative displacement and a wrapping base-plus-offset sum. A design that forgets the sign extension or truncates the carry writes back a wrong base. It checks the request address against the old base, so a unit that loads from the new sum fails at once. It puts junk in the upper half of single-precision responses and uses signed zero, infinity, a NaN payload and subnormals with leading ones at different positions, which catches a wrong word lane, a lost payload or an off-by-one normalization shift. It also stalls the request handshake, issues with base register zero and resets in mid-operation, which exposes a request that changes while stalled or a writeback that leaks out of an invalid form.

// File: rtl/fpld_pkg.sv
`timescale 1ns/1ps
package fpld_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fpld_state_e;

  localparam int SP_W       = 32;
  localparam int SP_EXP_W   = 8;
  localparam int SP_FRAC_W  = 23;
  localparam int DP_W       = 64;
  localparam int DP_EXP_W   = 11;
  localparam int DP_FRAC_W  = 52;
  localparam int SP_BIAS    = 127;
  localparam int DP_BIAS    = 1023;
  localparam int BIAS_DELTA = DP_BIAS - SP_BIAS;
  // exponent of a subnormal whose leading one sits at fraction bit 0
  localparam int SUB_BASE   = DP_BIAS - (SP_BIAS - 1) - SP_FRAC_W;
endpackage

// File: rtl/fpld_agen.sv
`timescale 1ns/1ps
module fpld_agen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   index_val,
  input  logic              use_index,
  output logic [XLEN-1:0]   sum
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] offset;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    offset   = use_index ? index_val : disp_ext;
    sum      = base_val + offset;   // wraps modulo 2^XLEN
  end
endmodule

// File: rtl/fpld_widen.sv
`timescale 1ns/1ps
module fpld_widen
  import fpld_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  output logic [DP_W-1:0] dp
);
  localparam int PAD_W  = DP_FRAC_W - SP_FRAC_W;
  localparam int LEAD_W = $clog2(SP_FRAC_W + 1);

  logic                  sgn;
  logic [SP_EXP_W-1:0]   exp_s;
  logic [SP_FRAC_W-1:0]  frac_s;
  logic [LEAD_W-1:0]     lead;
  logic [SP_FRAC_W:0]    shifted;
  logic [DP_EXP_W-1:0]   exp_d;
  logic [SP_FRAC_W-1:0]  frac_d;

  always_comb begin
    sgn    = sp[SP_W-1];
    exp_s  = sp[SP_W-2 -: SP_EXP_W];
    frac_s = sp[SP_FRAC_W-1:0];

    lead = '0;
    for (int i = 0; i < SP_FRAC_W; i++) begin
      if (frac_s[i]) lead = LEAD_W'(i);
    end
    shifted = {1'b0, frac_s} << (LEAD_W'(SP_FRAC_W) - lead);

    if (exp_s == '1) begin
      exp_d  = '1;
      frac_d = frac_s;
    end else if (exp_s == '0) begin
      if (frac_s == '0) begin
        exp_d  = '0;
        frac_d = '0;
      end else begin
        exp_d  = DP_EXP_W'(SUB_BASE) + DP_EXP_W'(lead);
        frac_d = shifted[SP_FRAC_W-1:0];
      end
    end else begin
      exp_d  = DP_EXP_W'(exp_s) + DP_EXP_W'(BIAS_DELTA);
      frac_d = frac_s;
    end
    dp = {sgn, exp_d, frac_d, {PAD_W{1'b0}}};
  end

  always_comb begin
    if (exp_s != '0 && exp_s != '1)
      assert_norm_exp_R5: assert (dp[DP_W-2 -: DP_EXP_W] > DP_EXP_W'(BIAS_DELTA));
  end
endmodule

// File: rtl/fpld_seq.sv
`timescale 1ns/1ps
module fpld_seq
  import fpld_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic              op_double,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   sum,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] tgt_idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  input  logic [XLEN-1:0]   widened,
  output logic              fpr_wb_valid,
  output logic [RIDX_W-1:0] fpr_wb_idx,
  output logic [XLEN-1:0]   fpr_wb_data,
  output logic              gpr_wb_valid,
  output logic [RIDX_W-1:0] gpr_wb_idx,
  output logic [XLEN-1:0]   gpr_wb_data,
  output logic              invalid_flag
);
  localparam logic [SIZE_W-1:0] SZ_SINGLE = SIZE_W'(SP_W / 8);
  localparam logic [SIZE_W-1:0] SZ_DOUBLE = SIZE_W'(DP_W / 8);

  fpld_state_e       state;
  logic [XLEN-1:0]   addr_q;
  logic [XLEN-1:0]   sum_q;
  logic [SIZE_W-1:0] size_q;
  logic              dbl_q;
  logic [RIDX_W-1:0] bidx_q;
  logic [RIDX_W-1:0] tidx_q;

  assign issue_ready   = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_size  = size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      fpr_wb_valid <= 1'b0;
      gpr_wb_valid <= 1'b0;
      invalid_flag <= 1'b0;
      addr_q       <= '0;
      sum_q        <= '0;
      size_q       <= SZ_SINGLE;
      dbl_q        <= 1'b0;
      bidx_q       <= '0;
      tidx_q       <= '0;
      fpr_wb_idx   <= '0;
      fpr_wb_data  <= '0;
      gpr_wb_idx   <= '0;
      gpr_wb_data  <= '0;
    end else begin
      fpr_wb_valid <= 1'b0;
      gpr_wb_valid <= 1'b0;
      invalid_flag <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (issue_valid) begin
            if (base_idx == '0) begin
              invalid_flag <= 1'b1;
            end else begin
              addr_q <= base_val;
              sum_q  <= sum;
              dbl_q  <= op_double;
              size_q <= op_double ? SZ_DOUBLE : SZ_SINGLE;
              bidx_q <= base_idx;
              tidx_q <= tgt_idx;
              state  <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            fpr_wb_valid <= 1'b1;
            gpr_wb_valid <= 1'b1;
            fpr_wb_idx   <= tidx_q;
            fpr_wb_data  <= dbl_q ? mem_rsp_data : widened;
            gpr_wb_idx   <= bidx_q;
            gpr_wb_data  <= sum_q;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_size_code_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_size == SZ_SINGLE || mem_req_size == SZ_DOUBLE));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  assert_wb_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    fpr_wb_valid |-> ($past(state) == ST_WAIT && $past(mem_rsp_valid) && gpr_wb_valid));

  assert_base_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    gpr_wb_valid |-> (gpr_wb_idx != '0));

  assert_invalid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    invalid_flag |-> (!mem_req_valid && !fpr_wb_valid && !gpr_wb_valid));

  assert_one_event_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({invalid_flag, fpr_wb_valid}));
endmodule

// File: rtl/fpld_postinc_unit.sv
`timescale 1ns/1ps
module fpld_postinc_unit #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 16,
  parameter int RIDX_W = 5,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic              op_double,
  input  logic              op_indexed,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   index_val,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] tgt_idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [SIZE_W-1:0] mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              fpr_wb_valid,
  output logic [RIDX_W-1:0] fpr_wb_idx,
  output logic [XLEN-1:0]   fpr_wb_data,
  output logic              gpr_wb_valid,
  output logic [RIDX_W-1:0] gpr_wb_idx,
  output logic [XLEN-1:0]   gpr_wb_data,
  output logic              invalid_flag
);
  logic [XLEN-1:0] sum;
  logic [63:0]     widened;

  fpld_agen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_agen (
    .base_val  (base_val),
    .disp      (disp),
    .index_val (index_val),
    .use_index (op_indexed),
    .sum       (sum)
  );

  fpld_widen u_widen (
    .sp (mem_rsp_data[31:0]),
    .dp (widened)
  );

  fpld_seq #(.XLEN(XLEN), .RIDX_W(RIDX_W), .SIZE_W(SIZE_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .issue_ready   (issue_ready),
    .op_double     (op_double),
    .base_val      (base_val),
    .sum           (sum),
    .base_idx      (base_idx),
    .tgt_idx       (tgt_idx),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_size  (mem_req_size),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .widened       (XLEN'(widened)),
    .fpr_wb_valid  (fpr_wb_valid),
    .fpr_wb_idx    (fpr_wb_idx),
    .fpr_wb_data   (fpr_wb_data),
    .gpr_wb_valid  (gpr_wb_valid),
    .gpr_wb_idx    (gpr_wb_idx),
    .gpr_wb_data   (gpr_wb_data),
    .invalid_flag  (invalid_flag)
  );
endmodule

// File: tb/fpld_postinc_unit_bench.sv
`timescale 1ns/1ps
module fpld_postinc_unit_bench;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic        op_double = 1'b0;
  logic        op_indexed = 1'b0;
  logic [63:0] base_val = '0;
  logic [15:0] disp = '0;
  logic [63:0] index_val = '0;
  logic [4:0]  base_idx = '0;
  logic [4:0]  tgt_idx = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [3:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        fpr_wb_valid;
  logic [4:0]  fpr_wb_idx;
  logic [63:0] fpr_wb_data;
  logic        gpr_wb_valid;
  logic [4:0]  gpr_wb_idx;
  logic [63:0] gpr_wb_data;
  logic        invalid_flag;

  always #2.5 clk = ~clk;

  fpld_postinc_unit u_fpld_postinc_unit (.*);

  localparam logic       V_DBL   [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
  localparam logic       V_IDX   [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 1, 0};
  localparam logic [63:0] V_BASE [NV] = '{
    64'h1000, 64'h1000, 64'h2000, 64'h0, 64'h40, 64'h80, 64'h90,
    64'hFFFF_FFFF_FFFF_FFF8, 64'h100, 64'h3000};
  localparam logic [15:0] V_DISP [NV] = '{
    16'h0010, 16'hFFF0, 16'h1234, 16'h7FFF, 16'h8000, 16'h0004, 16'h0,
    16'h0010, 16'h0, 16'hFFFF};
  localparam logic [63:0] V_INDEX [NV] = '{
    64'h0, 64'h0, 64'h8, 64'h0, 64'h0, 64'h0, 64'h20, 64'h0,
    64'hFFFF_FFFF_FFFF_FF00, 64'h0};
  localparam logic [63:0] V_DATA [NV] = '{
    64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_C049_0FDB, 64'hFFFF_FFFF_8000_0000,
    64'h1234_5678_7F80_0000, 64'h0000_0000_7FC0_0001, 64'hAAAA_AAAA_0000_0001,
    64'h0000_0000_0040_0000, 64'h0123_4567_89AB_CDEF, 64'hFFF0_0000_0000_0001,
    64'h5555_5555_0000_0003};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h3FF0_0000_0000_0000, 64'hC009_21FB_6000_0000, 64'h8000_0000_0000_0000,
    64'h7FF0_0000_0000_0000, 64'h7FF8_0000_2000_0000, 64'h36A0_0000_0000_0000,
    64'h3800_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFFF0_0000_0000_0001,
    64'h36B8_0000_0000_0000};

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic run_op(input int v, input int stall);
    logic [63:0] exp_sum;
    string sum_tag, fpr_tag;
    exp_sum = V_BASE[v] + (V_IDX[v] ? V_INDEX[v] : {{48{V_DISP[v][15]}}, V_DISP[v]});
    sum_tag = (v == 7 || v == 8) ? "R12 wrapped sum" : (V_IDX[v] ? "R2 indexed sum" : "R1 disp sum");
    if (V_DBL[v]) fpr_tag = "R7 double data";
    else if (V_DATA[v][30:23] == 8'h0 && V_DATA[v][22:0] != 23'h0) fpr_tag = "R6 subnormal widen";
    else fpr_tag = "R5 single widen";

    @(negedge clk);
    op_double  = V_DBL[v];
    op_indexed = V_IDX[v];
    base_val   = V_BASE[v];
    disp       = V_DISP[v];
    index_val  = V_INDEX[v];
    base_idx   = 5'(v + 1);
    tgt_idx    = 5'(31 - v);
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    base_val    = 64'hBAD0_BAD0_BAD0_BAD0;
    chk("R3 request valid", 64'(mem_req_valid), 64'd1);
    chk("R3 request addr", mem_req_addr, V_BASE[v]);
    chk("R4 request size", 64'(mem_req_size), V_DBL[v] ? 64'd8 : 64'd4);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R10 held valid", 64'(mem_req_valid), 64'd1);
      chk("R10 held addr", mem_req_addr, V_BASE[v]);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R10 request dropped", 64'(mem_req_valid), 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = V_DATA[v];
    chk("R8 no early writeback", 64'(fpr_wb_valid), 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    chk("R8 fpr valid", 64'(fpr_wb_valid), 64'd1);
    chk("R8 gpr valid", 64'(gpr_wb_valid), 64'd1);
    chk("R8 fpr idx", 64'(fpr_wb_idx), 64'(31 - v));
    chk("R8 gpr idx", 64'(gpr_wb_idx), 64'(v + 1));
    chk(fpr_tag, fpr_wb_data, V_EXP[v]);
    chk(sum_tag, gpr_wb_data, exp_sum);
    @(negedge clk);
    chk("R8 one-cycle writeback", 64'({fpr_wb_valid, gpr_wb_valid}), 64'd0);
    chk("R11 ready again", 64'(issue_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset ready", 64'(issue_ready), 64'd1);
    chk("R11 reset quiet", 64'({mem_req_valid, fpr_wb_valid, gpr_wb_valid, invalid_flag}), 64'd0);

    for (int v = 0; v < NV; v++) run_op(v, (v == 1 || v == 7) ? 3 : 0);

    // invalid form: base register 0
    @(negedge clk);
    op_double = 1'b1; op_indexed = 1'b0; base_val = 64'h500; disp = 16'h8;
    base_idx = 5'd0; tgt_idx = 5'd4; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R9 invalid flag", 64'(invalid_flag), 64'd1);
    chk("R9 no request", 64'(mem_req_valid), 64'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 quiet after invalid",
          64'({mem_req_valid, fpr_wb_valid, gpr_wb_valid, invalid_flag}), 64'd0);
    end

    // reset in mid-operation
    @(negedge clk);
    op_double = 1'b0; base_idx = 5'd3; base_val = 64'h600; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R3 request before reset", 64'(mem_req_valid), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 request abandoned", 64'(mem_req_valid), 64'd0);
    chk("R11 ready after reset", 64'(issue_ready), 64'd1);

    // the unit still works after the abandoned operation
    run_op(0, 1);

    finish_run();
  end
endmodule